// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a write-through first-level cache and the next memory level. It accepts processor stores in one cycle and holds them in a small set of line-sized entries. The lower level is written later through a ready/valid port, so the processor keeps running while the slow level catches up. Each entry holds one block address, a full line of data and one valid bit per word.

A normal store whose block already sits in an open entry is folded into that entry, and no new entry is taken. Stores flagged as I/O never fold and never receive folds, so each one keeps its own place in the drain order. Entries leave in the order they were created, one per lower-level transfer. The entry on offer at the drain port is closed to further stores. When every entry is taken and the store cannot fold, the processor is held off, unless the oldest entry leaves in that same cycle.

Top module: `merge_wbuf`

## Requirements
- R1: A store address is a word address. Its upper bits above log2(WORDS) form the block address and its low log2(WORDS) bits pick the word slot k. In a transfer, word k lies on `dn_data[k*DATA_W +: DATA_W]` and its valid bit is `dn_mask[k]`.
- R2: A non-I/O store whose block matches an open, non-I/O entry writes its word into that entry and sets that word's mask bit, without taking a new entry. A later store to the same word replaces the data.
- R3: A store that finds no open match takes a new entry. The mask of the new entry has only the stored word's bit set, and its other data words are zero.
- R4: A store with `st_io` high always takes a new entry of its own, and an entry created by an I/O store never receives a later store.
- R5: Entries leave in the order they were created, one entry for each cycle with `dn_valid` and `dn_ready` both high.
- R6: The oldest entry is the one offered on the drain port. While it waits, its block, data and mask stay unchanged, and a store to its block takes a new entry.
- R7: When all ENTRIES entries are taken and the store cannot fold, `st_ready` is low and the store is not taken. A store that can fold is still taken while full.
- R8: When all entries are taken and the oldest entry leaves in the current cycle, `st_ready` is high and a non-folding store is taken in that cycle.
- R9: After reset the buffer is empty, `dn_valid` is low and `st_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store taken this cycle when high with st_valid |
| st_addr | input | ADDR_W | Word address of the store |
| st_data | input | DATA_W | Store data |
| st_io | input | 1 | Store targets I/O space, never folded |
| dn_valid | output | 1 | Oldest entry is on offer |
| dn_ready | input | 1 | Lower level takes the offered entry |
| dn_blk | output | ADDR_W-log2(WORDS) | Block address of the offered entry |
| dn_data | output | WORDS*DATA_W | Line data of the offered entry |
| dn_mask | output | WORDS | Per-word valid bits of the offered entry |

## Verification
The assertions assume that the lower level obeys the handshake and that `st_addr`, `st_data` and `st_io` are defined whenever `st_valid` is high. The bench drives every input once per cycle, just after the rising edge, and keeps `st_valid` high for exactly one cycle per store. Most fold and allocate cases are run with `dn_ready` held low, so the bench's own model knows which entry is on offer. `dn_ready` is raised together with a store only in the full-and-draining case, and that store targets a block that is not pending, so the two events cannot interact.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
  // What a store does to the buffer in the cycle it is taken
  typedef enum logic [1:0] {
    WB_IDLE  = 2'd0,
    WB_FOLD  = 2'd1,
    WB_NEW   = 2'd2
  } wb_op_e;
endpackage

// File: rtl/mwb_ring.sv
module mwb_ring #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc,
  input  logic               drain,
  output logic [IDX_W-1:0]   head,
  output logic [IDX_W-1:0]   tail,
  output logic [ENTRIES-1:0] occ
);
  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(ENTRIES - 1)) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else begin
      if (drain) begin
        occ[head] <= 1'b0;
        head      <= next_idx(head);
      end
      if (alloc) begin
        occ[tail] <= 1'b1;
        tail      <= next_idx(tail);
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (!occ[tail] || (drain && head == tail))); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> occ[head]); // R5
endmodule

// File: rtl/mwb_match.sv
module mwb_match #(
  parameter int ENTRIES = 4,
  parameter int BLK_W   = 14,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [BLK_W-1:0]              blk,
  input  logic                          is_io,
  input  logic [ENTRIES-1:0]            occ,
  input  logic [ENTRIES-1:0]            io_q,
  input  logic [ENTRIES-1:0][BLK_W-1:0] tags,
  input  logic [IDX_W-1:0]              head,
  output logic [ENTRIES-1:0]            hit_vec,
  output logic                          hit
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic open_e;
    assign open_e     = occ[g] && !io_q[g] && (head != IDX_W'(g));
    assign hit_vec[g] = open_e && !is_io && (tags[g] == blk);
  end

  assign hit = |hit_vec;

  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
  parameter int ENTRIES = 4,
  parameter int WORDS   = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int BLK_W  = ADDR_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic              st_io,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [BLK_W-1:0]  dn_blk,
  output logic [LINE_W-1:0] dn_data,
  output logic [WORDS-1:0]  dn_mask
);
  import mwb_pkg::*;

  function automatic logic [BLK_W-1:0] block_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [WORDS-1:0] slot_bit(input logic [OFF_W-1:0] s);
    return WORDS'(1) << s;
  endfunction

  logic [ENTRIES-1:0][BLK_W-1:0] tag_q;
  logic [ENTRIES-1:0]            io_q;
  logic [WORDS-1:0]              mask_q [ENTRIES];
  logic [LINE_W-1:0]             data_q [ENTRIES];

  logic [IDX_W-1:0]   head, tail;
  logic [ENTRIES-1:0] occ;
  logic [ENTRIES-1:0] hit_vec;
  logic               hit;

  logic [BLK_W-1:0] in_blk;
  logic [OFF_W-1:0] in_slot;
  logic             can_alloc;
  logic             dn_fire;
  logic             st_fire;
  logic             do_fold;
  logic             do_new;
  wb_op_e           op;

  assign in_blk  = block_of(st_addr);
  assign in_slot = slot_of(st_addr);

  mwb_ring #(.ENTRIES(ENTRIES)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .alloc (do_new),
    .drain (dn_fire),
    .head  (head),
    .tail  (tail),
    .occ   (occ)
  );

  mwb_match #(.ENTRIES(ENTRIES), .BLK_W(BLK_W)) u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .blk     (in_blk),
    .is_io   (st_io),
    .occ     (occ),
    .io_q    (io_q),
    .tags    (tag_q),
    .head    (head),
    .hit_vec (hit_vec),
    .hit     (hit)
  );

  // Drain port: the oldest entry is always the one on offer
  assign dn_valid = occ[head];
  assign dn_blk   = tag_q[head];
  assign dn_data  = data_q[head];
  assign dn_mask  = mask_q[head];
  assign dn_fire  = dn_valid && dn_ready;

  // When full, tail equals head, so a leaving head frees the slot for this store
  assign can_alloc = !occ[tail] || (dn_fire && (tail == head));
  assign st_ready  = hit || can_alloc;
  assign st_fire   = st_valid && st_ready;

  always_comb begin
    op = WB_IDLE;
    if (st_fire) op = hit ? WB_FOLD : WB_NEW;
  end

  assign do_fold = (op == WB_FOLD);
  assign do_new  = (op == WB_NEW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_q <= '0;
      for (int i = 0; i < ENTRIES; i++) mask_q[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (do_new && tail == IDX_W'(i)) begin
          tag_q[i]  <= in_blk;
          io_q[i]   <= st_io;
          mask_q[i] <= slot_bit(in_slot);
          data_q[i] <= '0;
          data_q[i][int'(in_slot)*DATA_W +: DATA_W] <= st_data;
        end else if (do_fold && hit_vec[i]) begin
          mask_q[i] <= mask_q[i] | slot_bit(in_slot);
          data_q[i][int'(in_slot)*DATA_W +: DATA_W] <= st_data;
        end
      end
    end
  end

  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_blk) && $stable(dn_mask) && $stable(dn_data))); // R6
  AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |-> ((&occ) && !dn_fire)); // R7
  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (dn_mask != '0)); // R3
  AST_FULL_DRAIN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ((&occ) && dn_fire) |-> st_ready); // R8
endmodule

// File: tb/tb_merge_wbuf.sv
module tb_merge_wbuf;
  localparam int E  = 4;
  localparam int W  = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int BW = AW - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0, st_io = 1'b0, dn_ready = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_ready, dn_valid;
  logic [BW-1:0] dn_blk;
  logic [W*DW-1:0] dn_data;
  logic [W-1:0] dn_mask;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  merge_wbuf #(.ENTRIES(E), .WORDS(W), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_io(st_io),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_blk(dn_blk),
    .dn_data(dn_data), .dn_mask(dn_mask)
  );

  typedef struct {
    logic [BW-1:0]   blk;
    logic [W*DW-1:0] data;
    logic [W-1:0]    mask;
    bit              io;
  } ent_t;
  ent_t q[$];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Model: fold into an open non-I/O entry past the one on offer, else append
  task automatic model_store(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit io);
    logic [BW-1:0] b = a[AW-1:2];
    int s = int'(a[1:0]);
    int idx = -1;
    ent_t e;
    if (!io) begin
      for (int k = 1; k < q.size(); k++)
        if (!q[k].io && q[k].blk == b) idx = k;
    end
    if (idx >= 0) begin
      q[idx].data[s*DW +: DW] = d;
      q[idx].mask[s] = 1'b1;
    end else begin
      e.blk = b; e.data = '0; e.data[s*DW +: DW] = d;
      e.mask = '0; e.mask[s] = 1'b1; e.io = io;
      q.push_back(e);
    end
  endtask

  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit io,
                       input bit exp_rdy, input string tag);
    bit rdy;
    st_valid = 1'b1; st_addr = a; st_data = d; st_io = io;
    @(negedge clk);
    rdy = st_ready;
    chk(rdy == exp_rdy, tag, 128'(rdy), 128'(exp_rdy));
    @(posedge clk); #1;
    st_valid = 1'b0;
    if (rdy) model_store(a, d, io);
  endtask

  // Monitor: every accepted transfer is compared with the oldest modelled entry (R1 R5)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && dn_valid && dn_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R5 transfer with nothing pending", 128'(dn_blk), 128'(0));
        end else begin
          chk(dn_blk == q[0].blk, "R5 drain block order", 128'(dn_blk), 128'(q[0].blk));
          chk(dn_mask == q[0].mask, "R1 drain word mask", 128'(dn_mask), 128'(q[0].mask));
          chk(dn_data == q[0].data, "R1 drain line data", dn_data, q[0].data);
          void'(q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R5 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(dn_valid == 1'b0, "R9 reset dn_valid", 128'(dn_valid), 128'(0));
    chk(st_ready == 1'b1, "R9 reset st_ready", 128'(st_ready), 128'(1));
    @(posedge clk); #1;

    // Phase 1: drain held off; fold, closed head, I/O, full and stall
    store(16'h0041, 32'hA0000001, 1'b0, 1'b1, "R3 first store allocates");
    store(16'h0042, 32'hA0000002, 1'b0, 1'b1, "R6 store to offered block");
    store(16'h0043, 32'hA0000003, 1'b0, 1'b1, "R2 fold into open entry");
    store(16'h0043, 32'hB0000003, 1'b0, 1'b1, "R2 overwrite folded word");
    store(16'h0200, 32'hC0000000, 1'b1, 1'b1, "R4 io store own entry");
    store(16'h0201, 32'hC0000001, 1'b1, 1'b1, "R4 io store no fold");
    store(16'h0040, 32'hA0000000, 1'b0, 1'b1, "R7 fold taken while full");
    store(16'h0300, 32'hD0000000, 1'b0, 1'b0, "R7 stall when full");
    store(16'h0202, 32'hC0000002, 1'b1, 1'b0, "R7 io stall when full");
    @(negedge clk);
    chk(dn_valid == 1'b1, "R6 head on offer", 128'(dn_valid), 128'(1));
    chk(dn_blk == 14'h010, "R6 head block unchanged", 128'(dn_blk), 128'(14'h010));
    chk(dn_mask == 4'b0010, "R6 head mask unchanged", 128'(dn_mask), 128'(4'b0010));
    @(posedge clk); #1;

    dn_ready = 1'b1;
    store(16'h0300, 32'hD0000000, 1'b0, 1'b1, "R8 taken while head leaves");
    repeat (8) @(posedge clk);
    #1;
    chk(q.size() == 0, "R5 all phase-1 entries drained", 128'(q.size()), 128'(0));
    @(negedge clk);
    chk(dn_valid == 1'b0, "R5 empty after drain", 128'(dn_valid), 128'(0));
    @(posedge clk); #1;
    dn_ready = 1'b0;

    // Phase 2: I/O entry between folds of the same block
    store(16'h0500, 32'h11110000, 1'b0, 1'b1, "R3 new head entry");
    store(16'h0504, 32'h22220000, 1'b0, 1'b1, "R3 second block entry");
    store(16'h0505, 32'h33330001, 1'b1, 1'b1, "R4 io to pending block");
    store(16'h0506, 32'h22220002, 1'b0, 1'b1, "R2 fold past io entry");
    store(16'h0507, 32'h33330003, 1'b1, 1'b1, "R4 io fills buffer");
    store(16'h0507, 32'h22220003, 1'b0, 1'b1, "R7 fold into full buffer");
    for (int c = 0; c < 12; c++) begin
      dn_ready = c[0];
      @(posedge clk); #1;
    end
    dn_ready = 1'b0;
    chk(q.size() == 0, "R5 all phase-2 entries drained", 128'(q.size()), 128'(0));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule